// File: doc/BRIEF.md
# I2C Slave Address Detector

This block listens to a two-wire serial bus from the slave side. It synchronizes the clock and data lines to the system clock and recognizes START and STOP conditions. After each START it collects the first byte, most significant bit first. It compares the top seven bits of that byte with a programmed seven-bit address, and it compares the whole byte with the broadcast (general call) address.

When either comparison hits, the block pulls the data line low during the ninth clock pulse to acknowledge. It also raises a one-cycle pulse and a sticky flag for the kind of hit, and it latches the direction bit. When neither comparison hits, the block stays off the bus until the next START.

A frame-done level goes low at START and returns high at STOP, so the surrounding logic can tell when a slave frame is in progress. The block responds only while it is enabled. A disable request wins over an enable request that arrives in the same cycle. The data phase after the address byte is handled by other logic.

Top module: `i2c_addr_sniffer`

## Requirements
- R1: After reset, `sda_pull`, `own_hit`, `bcast_hit`, `rd_dir`, `hit_pulse` and `bcast_pulse` are 0, `enabled` is 0 and `done` is 1.
- R2: `enabled` becomes 1 one cycle after `en_set` and becomes 0 one cycle after `en_clr`. When both are high in the same cycle, `en_clr` wins. While disabled, bus activity causes no acknowledge, no flag and no pulse, and `done` stays 1.
- R3: A falling SDA while SCL is high (START) drives `done` low. A rising SDA while SCL is high (STOP) drives `done` back to 1.
- R4: When bits 7..1 of the first byte after START equal `my_addr`, `own_hit` is set and `hit_pulse` is high for exactly one cycle.
- R5: A first byte of 8'h00 sets `bcast_hit` and gives one `bcast_pulse`. A first byte of 8'h01 is not a broadcast hit. When `my_addr` is 0, a first byte of 8'h00 sets both flags.
- R6: Bit 0 of the first byte is latched as the direction. `rd_dir` is 1 for read (bit 0 = 1) and 0 for write, and it is forced to 0 while `own_hit` is 0.
- R7: On any hit, `sda_pull` rises after the SCL fall that ends the eighth bit and falls after the SCL fall that ends the ninth bit. On a miss, `sda_pull` stays 0 until the next START.
- R8: Every START clears `own_hit`, `bcast_hit` and `rd_dir` and restarts address collection, including a repeated START without a STOP. A STOP leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen on the pad |
| sda_in | input | 1 | Bus data line as seen on the pad |
| en_set | input | 1 | Request to enable slave response |
| en_clr | input | 1 | Request to disable slave response (wins over en_set) |
| my_addr | input | AW | Programmed slave address |
| sda_pull | output | 1 | 1 drives the data line low (acknowledge) |
| hit_pulse | output | 1 | One-cycle pulse on a programmed-address hit |
| bcast_pulse | output | 1 | One-cycle pulse on a broadcast hit |
| own_hit | output | 1 | Programmed-address hit flag for the current frame |
| bcast_hit | output | 1 | Broadcast hit flag for the current frame |
| rd_dir | output | 1 | Direction of the access (1 = read), valid while own_hit is 1 |
| done | output | 1 | 0 from a received START to a received STOP |
| enabled | output | 1 | Slave response enabled |

## Verification
Two pairs of functions can act in the same cycle.

The first pair is the enable and disable requests. The bench raises both in one cycle and then sends an address that would otherwise match. It expects the block to end up disabled, with no acknowledge and `done` still high.

The second pair is the two address comparisons. The bench programs address 0 and sends byte 8'h00, so both comparisons hit at once. It expects both flags and both pulses together with one acknowledge bit.

Randomly chosen frames mix hits, misses, read and write directions and enable toggles. Each one is checked against expected values computed from the byte, the address and the enable state.

// File: rtl/i2c_addr_sniffer.sv
module i2c_addr_sniffer #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          en_set,
  input  logic          en_clr,
  input  logic [AW-1:0] my_addr,
  output logic          sda_pull,
  output logic          hit_pulse,
  output logic          bcast_pulse,
  output logic          own_hit,
  output logic          bcast_hit,
  output logic          rd_dir,
  output logic          done,
  output logic          enabled
);
  localparam int BW = AW + 1;
  localparam int CW = $clog2(BW + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ACKW, S_ACK, S_SKIP} st_t;

  st_t           st;
  logic [2:0]    scl_q, sda_q;
  logic [AW-1:0] shreg;
  logic [CW-1:0] cnt;
  logic          busy, rw_q;

  wire scl_hi    = scl_q[1] & scl_q[2];
  wire start_det = scl_hi & sda_q[2] & ~sda_q[1];
  wire stop_det  = scl_hi & ~sda_q[2] & sda_q[1];
  wire scl_rise  = scl_q[1] & ~scl_q[2];
  wire scl_fall  = ~scl_q[1] & scl_q[2];

  wire [BW-1:0] byte_now = {shreg, sda_q[1]};
  wire          own_eq   = byte_now[BW-1:1] == my_addr;
  wire          gc_eq    = byte_now == '0;
  wire          last_bit = cnt == CW'(BW - 1);

  assign done   = ~busy;
  assign rd_dir = rw_q & own_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      shreg       <= '0;
      cnt         <= '0;
      busy        <= 1'b0;
      rw_q        <= 1'b0;
      enabled     <= 1'b0;
      sda_pull    <= 1'b0;
      hit_pulse   <= 1'b0;
      bcast_pulse <= 1'b0;
      own_hit     <= 1'b0;
      bcast_hit   <= 1'b0;
    end else begin
      hit_pulse   <= 1'b0;
      bcast_pulse <= 1'b0;
      enabled     <= en_clr ? 1'b0 : (en_set ? 1'b1 : enabled);
      if (en_clr || !enabled) begin
        st        <= S_IDLE;
        busy      <= 1'b0;
        sda_pull  <= 1'b0;
        own_hit   <= 1'b0;
        bcast_hit <= 1'b0;
        rw_q      <= 1'b0;
      end else if (start_det) begin
        st        <= S_ADDR;
        cnt       <= '0;
        busy      <= 1'b1;
        sda_pull  <= 1'b0;
        own_hit   <= 1'b0;
        bcast_hit <= 1'b0;
        rw_q      <= 1'b0;
      end else if (stop_det) begin
        st       <= S_IDLE;
        busy     <= 1'b0;
        sda_pull <= 1'b0;
      end else begin
        case (st)
          S_ADDR: if (scl_rise) begin
            shreg <= byte_now[AW-1:0];
            cnt   <= cnt + 1'b1;
            if (last_bit) begin
              if (own_eq || gc_eq) begin
                own_hit     <= own_eq;
                bcast_hit   <= gc_eq;
                hit_pulse   <= own_eq;
                bcast_pulse <= gc_eq;
                rw_q        <= byte_now[0];
                st          <= S_ACKW;
              end else begin
                st <= S_SKIP;
              end
            end
          end
          S_ACKW: if (scl_fall) begin
            sda_pull <= 1'b1;
            st       <= S_ACK;
          end
          S_ACK: if (scl_fall) begin
            sda_pull <= 1'b0;
            st       <= S_SKIP;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module i2c_addr_sniffer_chk (
  input logic clk,
  input logic rst_n,
  input logic en_set,
  input logic en_clr,
  input logic sda_pull,
  input logic hit_pulse,
  input logic bcast_pulse,
  input logic own_hit,
  input logic bcast_hit,
  input logic done,
  input logic enabled
);
  assert_clr_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr |=> !enabled);
  assert_quiet_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |-> !sda_pull);
  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_pulse |=> !hit_pulse);
  assert_pulse_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_pulse |-> own_hit);
  assert_bcast_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_pulse |-> bcast_hit);
  assert_pull_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> !done);
  assert_pull_needs_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> (own_hit || bcast_hit));
endmodule

bind i2c_addr_sniffer i2c_addr_sniffer_chk chk_i (.*);

// File: tb/i2c_addr_sniffer_tb_top.sv
`timescale 1ns/1ps
module i2c_addr_sniffer_tb_top;
  localparam int H = 8;

  logic clk = 0, rst_n = 0;
  logic m_scl = 1, m_sda = 1;
  logic en_set = 0, en_clr = 0;
  logic [6:0] my_addr = 7'h2A;
  logic sda_pull, hit_pulse, bcast_pulse, own_hit, bcast_hit, rd_dir, done, enabled;
  wire sda_bus = m_sda & ~sda_pull;

  int checks = 0, fails = 0, hits = 0, bhits = 0;
  logic model_en = 0;

  always #2.5 clk = ~clk;

  i2c_addr_sniffer dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
    .en_set(en_set), .en_clr(en_clr), .my_addr(my_addr),
    .sda_pull(sda_pull), .hit_pulse(hit_pulse), .bcast_pulse(bcast_pulse),
    .own_hit(own_hit), .bcast_hit(bcast_hit), .rd_dir(rd_dir),
    .done(done), .enabled(enabled));

  always @(posedge clk) begin
    if (hit_pulse) hits++;
    if (bcast_pulse) bhits++;
  end

  function automatic logic exp_own(input logic [7:0] b, input logic [6:0] a, input logic e);
    return e && (b[7:1] == a);
  endfunction
  function automatic logic exp_gc(input logic [7:0] b, input logic e);
    return e && (b == 8'h00);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    m_sda = 1; m_scl = 1; wait_n(H);
    m_sda = 0; wait_n(H);
    m_scl = 0; wait_n(H);
  endtask

  task automatic do_bit(input logic b);
    m_sda = b; wait_n(H);
    m_scl = 1; wait_n(H);
    m_scl = 0; wait_n(H);
  endtask

  task automatic do_ack(output logic seen);
    m_sda = 1; wait_n(H);
    m_scl = 1; wait_n(H / 2);
    seen = sda_pull;
    wait_n(H / 2);
    m_scl = 0; wait_n(H);
  endtask

  task automatic do_stop();
    m_sda = 0; wait_n(H);
    m_scl = 1; wait_n(H);
    m_sda = 1; wait_n(H);
  endtask

  task automatic send_addr(input logic [7:0] b, output logic ack);
    do_start();
    for (int i = 7; i >= 0; i--) do_bit(b[i]);
    do_ack(ack);
  endtask

  task automatic frame(input logic [7:0] b, input string tag);
    logic ack;
    int h0, g0;
    logic eo, eg;
    h0 = hits; g0 = bhits;
    eo = exp_own(b, my_addr, model_en);
    eg = exp_gc(b, model_en);
    send_addr(b, ack);
    check({"R7 ack ", tag}, ack, eo | eg);
    check({"R3 busy ", tag}, done, !model_en);
    check({"R4 own ", tag}, own_hit, eo);
    check({"R5 bcast ", tag}, bcast_hit, eg);
    check({"R6 dir ", tag}, rd_dir, eo & b[0]);
    check({"R4 pulses ", tag}, hits - h0, eo);
    check({"R5 pulses ", tag}, bhits - g0, eg);
    wait_n(H);
    check({"R7 released ", tag}, sda_pull, 0);
    do_stop();
    wait_n(4);
    check({"R3 done ", tag}, done, 1);
    check({"R8 keep ", tag}, own_hit, eo);
  endtask

  task automatic req_en(input logic s, input logic c);
    en_set = s; en_clr = c; wait_n(1);
    en_set = 0; en_clr = 0; wait_n(1);
    if (c) model_en = 0; else if (s) model_en = 1;
    check("R2 enabled", enabled, model_en);
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic ack;
    logic [7:0] b;
    int seed_dummy;
    seed_dummy = $urandom(32'h1c5e_0a17);
    wait_n(4);
    rst_n = 1;
    wait_n(2);
    check("R1 pull", sda_pull, 0);
    check("R1 flags", {own_hit, bcast_hit, rd_dir, hit_pulse, bcast_pulse}, 0);
    check("R1 done", done, 1);
    check("R1 enabled", enabled, 0);

    frame({7'h2A, 1'b0}, "disabled");
    req_en(1, 1);
    frame({7'h2A, 1'b1}, "set+clr");
    req_en(1, 0);
    frame({7'h2A, 1'b1}, "read");
    frame({7'h2A, 1'b0}, "write");
    frame(8'h00, "gc");
    frame(8'h01, "gc read");
    frame(8'h54 ^ 8'h02, "miss");

    send_addr(8'h10, ack);
    check("R7 miss before rs", ack, 0);
    send_addr({7'h2A, 1'b1}, ack);
    check("R8 repeated start ack", ack, 1);
    check("R8 rs dir", rd_dir, 1);
    send_addr(8'h12, ack);
    check("R8 cleared on start", {own_hit, rd_dir}, 0);
    check("R7 no pull after miss", ack, 0);
    do_stop(); wait_n(4);
    check("R3 done rs", done, 1);

    my_addr = 7'h00;
    hits = 0; bhits = 0;
    frame(8'h00, "both");

    for (int n = 0; n < 40; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0) req_en(0, 1);
      else if (r == 1) req_en(1, 0);
      my_addr = 7'($urandom_range(1, 127));
      r = $urandom_range(0, 5);
      if (r < 2) b = {my_addr, 1'($urandom_range(0, 1))};
      else if (r == 2) b = 8'h00;
      else b = 8'($urandom_range(0, 255));
      frame(b, "random");
    end
    req_en(1, 0);
    frame({my_addr, 1'b1}, "final");
    report();
  end
endmodule